// File: doc/BRIEF.md
# Round-Robin Dual-Address Lock Arbiter

This block is the central point where hardware threads acquire locks on cache lines before a two-address atomic swap. Each thread hands in lock requests that name two line addresses. The arbiter holds them in a private pair of pending slots per thread. It evaluates one pending request per cycle, choosing threads in rotating order, and answers each one with a grant or a refusal. A granted request records both lines in a small lock table, tagged with the requesting thread. A refused request records nothing, and the requester is expected to retry. A separate release port lets a thread drop the two lines it holds.

The lock table is a set of entries, each with a valid bit, a line address and an owner id. Lookup, allocation and release all act on it in a single cycle. Threads that are idle cost no evaluation time. The rotating pointer only decides who goes first among the threads that have work pending, so a lone requester is answered at once. Every thread with a pending request is reached within one full rotation.

Top module: `lockarb_top`

## Requirements
- R1: Each thread has two pending slots. `req_ready[t]` is low exactly while two requests of thread t await evaluation. A request offered while `req_ready[t]` is low is dropped and never answered.
- R2: At most one request is evaluated per cycle. It belongs to the first thread with a pending request, searching upward from the rotating pointer and wrapping past the last thread. After an evaluation the pointer moves to the evaluated thread plus one, whatever the answer was.
- R3: The oldest pending request of the chosen thread is evaluated. A request taken in at clock edge k with no other work pending is answered at edge k+1 (`resp_valid`=1, `resp_tid`, `resp_ack`).
- R4: `resp_ack`=1 (grant) when neither line is held by another thread and the table has enough free entries. Both lines are then recorded with the requester as owner.
- R5: `resp_ack`=0 (refusal) when either line is held by another thread. In that case neither line is recorded.
- R6: A request whose two lines are equal needs, and takes, only one table entry. The table never holds two valid entries for the same line.
- R7: A request is refused when the table has fewer free entries than the number of new lines it needs.
- R8: A line that the requester already holds counts as neither a conflict nor a new entry.
- R9: A release (`rel_valid`) by the owning thread frees its matching entries at the same edge. A request evaluated in the following cycle can then be granted those lines.
- R10: A release naming a line held by another thread leaves that entry in place and raises `rel_err` for one cycle. A release naming an unlocked line has no effect and raises no error.
- R11: After reset no request is pending, the table is empty, the pointer is 0, `resp_valid` and `rel_err` are low and every `req_ready` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_THREADS | Per-thread lock request strobe |
| req_line_a | input | N_THREADS*ADDR_W | First line address per thread, thread t at bits [t*ADDR_W +: ADDR_W] |
| req_line_b | input | N_THREADS*ADDR_W | Second line address per thread, same packing |
| req_ready | output | N_THREADS | Thread has a free pending slot |
| rel_valid | input | 1 | Release strobe |
| rel_tid | input | $clog2(N_THREADS) | Thread issuing the release |
| rel_line_a | input | ADDR_W | First line to release |
| rel_line_b | input | ADDR_W | Second line to release |
| resp_valid | output | 1 | An evaluation answer is present |
| resp_tid | output | $clog2(N_THREADS) | Thread being answered |
| resp_ack | output | 1 | 1 = grant, 0 = refusal |
| rel_err | output | 1 | Previous release named a line owned by another thread |

## Verification
The bench builds the arbiter with 8 threads, 4-bit line addresses and a 4-entry lock table. With only 16 lines, random requests collide often, so refusals, same-line pairs and self-held lines all appear frequently. With only 4 entries, the table fills up and refusals for lack of room occur within a few cycles. With 8 threads, a burst from every thread saturates both slots and drops requests. Full rotations of the pointer stay short enough that the wrap-around order is seen many times.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;

  typedef enum logic {
    RSP_NACK = 1'b0,
    RSP_ACK  = 1'b1
  } rsp_e;

endpackage

// File: rtl/lockarb_slots.sv
module lockarb_slots #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_a,
  input  logic [ADDR_W-1:0] push_b,
  input  logic              pop,
  output logic              ready,
  output logic              pending,
  output logic [ADDR_W-1:0] head_a,
  output logic [ADDR_W-1:0] head_b
);

  logic [1:0]        cnt_q, cnt_d;
  logic [ADDR_W-1:0] a_q [2];
  logic [ADDR_W-1:0] b_q [2];
  logic [ADDR_W-1:0] a_d [2];
  logic [ADDR_W-1:0] b_d [2];
  logic              en;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    cnt_d = cnt_q;
    if (pop && cnt_q != 2'd0) begin
      a_d[0] = a_q[1];
      b_d[0] = b_q[1];
      cnt_d  = cnt_q - 2'd1;
    end
    if (push && cnt_q != 2'd2) begin
      a_d[cnt_d[0]] = push_a;
      b_d[cnt_d[0]] = push_b;
      cnt_d         = cnt_d + 2'd1;
    end
  end

  assign en = push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else if (en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign ready   = (cnt_q != 2'd2);
  assign pending = (cnt_q != 2'd0);
  assign head_a  = a_q[0];
  assign head_b  = b_q[0];

endmodule

// File: rtl/lockarb_rr_pick.sv
module lockarb_rr_pick #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] ptr,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/lockarb_registry.sv
module lockarb_registry #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int TID_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_a,
  input  logic [ADDR_W-1:0] lk_b,
  output logic              hit_a,
  output logic [TID_W-1:0]  own_a,
  output logic              hit_b,
  output logic [TID_W-1:0]  own_b,
  output logic              room1,
  output logic              room2,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [TID_W-1:0]  wr_owner,
  input  logic              rel_en,
  input  logic [TID_W-1:0]  rel_owner,
  input  logic [ADDR_W-1:0] rel_a,
  input  logic [ADDR_W-1:0] rel_b,
  output logic              rel_foreign
);

  localparam int DIX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  v_q, v_d;
  logic [ADDR_W-1:0] a_q   [DEPTH];
  logic [TID_W-1:0]  own_q [DEPTH];
  logic [ADDR_W-1:0] wd    [DEPTH];
  logic [DEPTH-1:0]  we;
  logic [DIX_W-1:0]  f0, f1, fb;

  // lookup of the two requested lines
  always_comb begin
    hit_a = 1'b0; own_a = '0;
    hit_b = 1'b0; own_b = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (v_q[i] && a_q[i] == lk_a) begin
        hit_a = 1'b1;
        own_a = own_q[i];
      end
      if (v_q[i] && a_q[i] == lk_b) begin
        hit_b = 1'b1;
        own_b = own_q[i];
      end
    end
  end

  // first two free entries
  always_comb begin
    room1 = 1'b0; room2 = 1'b0;
    f0 = '0; f1 = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!v_q[i]) begin
        if (!room1) begin
          room1 = 1'b1;
          f0    = DIX_W'(i);
        end else if (!room2) begin
          room2 = 1'b1;
          f1    = DIX_W'(i);
        end
      end
    end
  end

  assign fb = wr_a ? f1 : f0;

  // release clears owner-matching entries, grant fills free ones
  always_comb begin
    v_d         = v_q;
    we          = '0;
    rel_foreign = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      wd[i] = lk_a;
      if (rel_en && v_q[i] && (a_q[i] == rel_a || a_q[i] == rel_b)) begin
        if (own_q[i] == rel_owner) v_d[i] = 1'b0;
        else rel_foreign = 1'b1;
      end
      if (wr_a && f0 == DIX_W'(i)) begin
        we[i]  = 1'b1;
        v_d[i] = 1'b1;
        wd[i]  = lk_a;
      end
      if (wr_b && fb == DIX_W'(i)) begin
        we[i]  = 1'b1;
        v_d[i] = 1'b1;
        wd[i]  = lk_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else if (rel_en | wr_a | wr_b) v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we[i]) begin
        a_q[i]   <= wd[i];
        own_q[i] <= wr_owner;
      end
    end
  end

endmodule

// File: rtl/lockarb_top.sv
module lockarb_top
  import lockarb_pkg::*;
#(
  parameter int N_THREADS  = 32,
  parameter int ADDR_W     = 16,
  parameter int LOCK_DEPTH = 8,
  localparam int TID_W     = $clog2(N_THREADS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_THREADS-1:0]          req_valid,
  input  logic [N_THREADS*ADDR_W-1:0]   req_line_a,
  input  logic [N_THREADS*ADDR_W-1:0]   req_line_b,
  output logic [N_THREADS-1:0]          req_ready,
  input  logic                          rel_valid,
  input  logic [TID_W-1:0]              rel_tid,
  input  logic [ADDR_W-1:0]             rel_line_a,
  input  logic [ADDR_W-1:0]             rel_line_b,
  output logic                          resp_valid,
  output logic [TID_W-1:0]              resp_tid,
  output logic                          resp_ack,
  output logic                          rel_err
);

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic [N_THREADS-1:0] pend, pop;
  logic [ADDR_W-1:0] head_a [N_THREADS];
  logic [ADDR_W-1:0] head_b [N_THREADS];
  logic              pick_vld;
  logic [TID_W-1:0]  pick_id, ptr_q, ptr_d;
  logic [ADDR_W-1:0] sel_a, sel_b;
  logic              hit_a, hit_b, room1, room2, rel_foreign;
  logic [TID_W-1:0]  own_a, own_b;
  logic              same, conf, need_a, need_b, room, grant;
  logic              rv_q, err_q;
  logic [TID_W-1:0]  tid_q;
  rsp_e              rsp_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    assign pop[t] = pick_vld && (pick_id == TID_W'(t));
    lockarb_slots #(.ADDR_W(ADDR_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .push   (req_valid[t]),
      .push_a (req_line_a[t*ADDR_W +: ADDR_W]),
      .push_b (req_line_b[t*ADDR_W +: ADDR_W]),
      .pop    (pop[t]),
      .ready  (req_ready[t]),
      .pending(pend[t]),
      .head_a (head_a[t]),
      .head_b (head_b[t])
    );
  end

  lockarb_rr_pick #(.N(N_THREADS), .IDX_W(TID_W)) u_pick (
    .req  (pend),
    .ptr  (ptr_q),
    .found(pick_vld),
    .idx  (pick_id)
  );

  assign sel_a = head_a[pick_id];
  assign sel_b = head_b[pick_id];

  lockarb_registry #(.DEPTH(LOCK_DEPTH), .ADDR_W(ADDR_W), .TID_W(TID_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lk_a       (sel_a),
    .lk_b       (sel_b),
    .hit_a      (hit_a),
    .own_a      (own_a),
    .hit_b      (hit_b),
    .own_b      (own_b),
    .room1      (room1),
    .room2      (room2),
    .wr_a       (grant && need_a),
    .wr_b       (grant && need_b),
    .wr_owner   (pick_id),
    .rel_en     (rel_valid),
    .rel_owner  (rel_tid),
    .rel_a      (rel_line_a),
    .rel_b      (rel_line_b),
    .rel_foreign(rel_foreign)
  );

  // all-or-nothing decision on the evaluated request
  always_comb begin
    same   = (sel_a == sel_b);
    conf   = (hit_a && own_a != pick_id) || (hit_b && own_b != pick_id);
    need_a = !hit_a;
    need_b = !hit_b && !same;
    if (need_a && need_b)      room = room2;
    else if (need_a || need_b) room = room1;
    else                       room = 1'b1;
    grant  = pick_vld && !conf && room;
    ptr_d  = (pick_id == TID_W'(N_THREADS - 1)) ? '0 : pick_id + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ptr_q <= '0;
      rv_q  <= 1'b0;
      tid_q <= '0;
      rsp_q <= RSP_NACK;
      err_q <= 1'b0;
    end else begin
      rv_q  <= pick_vld;
      err_q <= rel_valid && rel_foreign;
      if (pick_vld) begin
        ptr_q <= ptr_d;
        tid_q <= pick_id;
        rsp_q <= grant ? RSP_ACK : RSP_NACK;
      end
    end
  end

  assign resp_valid = rv_q;
  assign resp_tid   = tid_q;
  assign resp_ack   = (rsp_q == RSP_ACK);
  assign rel_err    = err_q;

endmodule

// File: rtl/lockarb_checkers.sv
module lockarb_top_chk #(
  parameter int N_THREADS = 32,
  parameter int TID_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_THREADS-1:0] req_valid,
  input logic [N_THREADS-1:0] req_ready,
  input logic                 rel_valid,
  input logic                 rel_err,
  input logic                 resp_valid,
  input logic [TID_W-1:0]     resp_tid
);

  AST_ERR_FOLLOWS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_valid)); // R10

  AST_READY_FALLS_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(req_ready) & ~req_ready & ~$past(req_valid)) == '0)); // R1

  AST_RESP_TID_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !$isunknown(resp_tid)); // R2

endmodule

module lockarb_reg_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DEPTH-1:0]  v_q,
  input logic [ADDR_W-1:0] a_q [DEPTH],
  input logic              wr_a,
  input logic              wr_b,
  input logic              rel_en
);

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = i + 1; j < DEPTH; j++)
        if (v_q[i] && v_q[j] && a_q[i] == a_q[j]) dup = 1'b1;
  end

  AST_NO_DUPLICATE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !dup); // R6

  AST_GROWTH_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(v_q) > $countones($past(v_q))) |-> $past(wr_a || wr_b)); // R4

  AST_SHRINK_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(v_q) < $countones($past(v_q))) |-> $past(rel_en)); // R9

endmodule

bind lockarb_top lockarb_top_chk #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_top_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rel_valid(rel_valid), .rel_err(rel_err), .resp_valid(resp_valid), .resp_tid(resp_tid)
);

bind lockarb_registry lockarb_reg_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_reg_chk (
  .clk(clk), .rst_n(rst_n), .v_q(v_q), .a_q(a_q), .wr_a(wr_a), .wr_b(wr_b), .rel_en(rel_en)
);

// File: tb/lockarb_top_test.sv
module lockarb_top_test;

  localparam int N  = 8;
  localparam int AW = 4;
  localparam int D  = 4;
  localparam int TW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    req_valid, req_ready;
  logic [N*AW-1:0] req_line_a, req_line_b;
  logic            rel_valid, resp_valid, resp_ack, rel_err;
  logic [TW-1:0]   rel_tid, resp_tid;
  logic [AW-1:0]   rel_line_a, rel_line_b;

  // stimulus
  logic [N-1:0]  s_rv;
  logic [AW-1:0] s_a [N];
  logic [AW-1:0] s_b [N];
  logic          s_relv;
  logic [TW-1:0] s_relt;
  logic [AW-1:0] s_ra, s_rb;

  always_comb begin
    for (int t = 0; t < N; t++) begin
      req_line_a[t*AW +: AW] = s_a[t];
      req_line_b[t*AW +: AW] = s_b[t];
    end
  end
  assign req_valid  = s_rv;
  assign rel_valid  = s_relv;
  assign rel_tid    = s_relt;
  assign rel_line_a = s_ra;
  assign rel_line_b = s_rb;

  lockarb_top #(.N_THREADS(N), .ADDR_W(AW), .LOCK_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line_a(req_line_a),
    .req_line_b(req_line_b), .req_ready(req_ready), .rel_valid(rel_valid),
    .rel_tid(rel_tid), .rel_line_a(rel_line_a), .rel_line_b(rel_line_b),
    .resp_valid(resp_valid), .resp_tid(resp_tid), .resp_ack(resp_ack), .rel_err(rel_err)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  // reference model state
  int            mcnt [N];
  logic [AW-1:0] mqa [N][2];
  logic [AW-1:0] mqb [N][2];
  bit            mv [D];
  logic [AW-1:0] ma [D];
  int            mo [D];
  int            mptr;
  bit            exp_rv, exp_ack, exp_err;
  int            exp_tid;
  logic [N-1:0]  exp_ready;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_stim();
    s_rv = '0;
    for (int t = 0; t < N; t++) begin s_a[t] = '0; s_b[t] = '0; end
    s_relv = 1'b0; s_relt = '0; s_ra = '0; s_rb = '0;
  endtask

  task automatic model_step();
    bit rdy [N];
    bit found, hit_a, hit_b, conf, need_a, need_b, ok;
    int sel, own_a, own_b, nf, need;
    int freel [D];
    logic [AW-1:0] a, b;
    found = 0; sel = 0; ok = 0; need_a = 0; need_b = 0;
    for (int t = 0; t < N; t++) rdy[t] = (mcnt[t] < 2);
    for (int k = 0; k < N; k++) begin
      int t;
      t = (mptr + k) % N;
      if (!found && mcnt[t] > 0) begin found = 1; sel = t; end
    end
    nf = 0;
    for (int i = 0; i < D; i++) if (!mv[i]) begin freel[nf] = i; nf++; end
    if (found) begin
      a = mqa[sel][0]; b = mqb[sel][0];
      hit_a = 0; hit_b = 0; own_a = 0; own_b = 0;
      for (int i = 0; i < D; i++) begin
        if (mv[i] && ma[i] == a) begin hit_a = 1; own_a = mo[i]; end
        if (mv[i] && ma[i] == b) begin hit_b = 1; own_b = mo[i]; end
      end
      conf   = (hit_a && own_a != sel) || (hit_b && own_b != sel);
      need_a = !hit_a;
      need_b = !hit_b && (a != b);
      need   = int'(need_a) + int'(need_b);
      ok     = !conf && (nf >= need);
    end
    exp_rv = found;
    if (found) begin exp_tid = sel; exp_ack = ok; mptr = (sel + 1) % N; end
    exp_err = 0;
    if (s_relv) begin
      for (int i = 0; i < D; i++) begin
        if (mv[i] && (ma[i] == s_ra || ma[i] == s_rb)) begin
          if (mo[i] == int'(s_relt)) mv[i] = 0;
          else exp_err = 1;
        end
      end
    end
    if (found && ok) begin
      if (need_a) begin mv[freel[0]] = 1; ma[freel[0]] = a; mo[freel[0]] = sel; end
      if (need_b) begin
        int p;
        p = need_a ? freel[1] : freel[0];
        mv[p] = 1; ma[p] = b; mo[p] = sel;
      end
    end
    if (found) begin
      mqa[sel][0] = mqa[sel][1]; mqb[sel][0] = mqb[sel][1];
      mcnt[sel]--;
    end
    for (int t = 0; t < N; t++) begin
      if (s_rv[t] && rdy[t]) begin
        mqa[t][mcnt[t]] = s_a[t]; mqb[t][mcnt[t]] = s_b[t];
        mcnt[t]++;
      end
      exp_ready[t] = (mcnt[t] < 2);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R3 resp_valid", int'(resp_valid), int'(exp_rv));
    if (exp_rv) begin
      chk("R2 resp_tid", int'(resp_tid), exp_tid);
      chk("R4 R5 R7 resp_ack", int'(resp_ack), int'(exp_ack));
    end
    chk("R1 req_ready", int'(req_ready), int'(exp_ready));
    chk("R10 rel_err", int'(rel_err), int'(exp_err));
    clear_stim();
  endtask

  task automatic req(int t, int a, int b);
    s_rv[t] = 1'b1; s_a[t] = AW'(a); s_b[t] = AW'(b);
  endtask

  task automatic rel(int t, int a, int b);
    s_relv = 1'b1; s_relt = TW'(t); s_ra = AW'(a); s_rb = AW'(b);
  endtask

  task automatic drain_all();
    for (int n = 0; n < 200; n++) begin
      bit busy;
      busy = 0;
      for (int t = 0; t < N; t++) if (mcnt[t] > 0) busy = 1;
      for (int i = 0; i < D; i++) begin
        if (mv[i] && !s_relv) begin rel(mo[i], int'(ma[i]), int'(ma[i])); busy = 1; end
      end
      if (!busy && !s_relv) break;
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R3 actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    clear_stim();
    for (int t = 0; t < N; t++) mcnt[t] = 0;
    for (int i = 0; i < D; i++) begin mv[i] = 0; ma[i] = '0; mo[i] = 0; end
    mptr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 resp_valid in reset", int'(resp_valid), 0);
    chk("R11 req_ready in reset", int'(req_ready), (1 << N) - 1);
    chk("R11 rel_err in reset", int'(rel_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 resp_valid after reset", int'(resp_valid), 0);
    chk("R11 req_ready after reset", int'(req_ready), (1 << N) - 1);

    // lone requester answered one edge after intake
    req(3, 1, 2); tick();
    tick();
    chk("R3 lone request answered", int'(resp_valid), 1);
    chk("R3 lone request tid", int'(resp_tid), 3);
    chk("R4 lone request granted", int'(resp_ack), 1);

    // conflict on one line: refused, other line not recorded
    req(5, 2, 7); tick(); tick();
    chk("R5 conflict refused", int'(resp_ack), 0);
    req(5, 7, 7); tick(); tick();
    chk("R6 same-line pair granted, line 7 was free", int'(resp_ack), 1);

    // foreign release keeps the lock and flags
    rel(6, 1, 2); tick();
    chk("R10 foreign release flagged", int'(rel_err), 1);
    req(4, 1, 9); tick(); tick();
    chk("R10 lock kept after foreign release", int'(resp_ack), 0);

    // owner release frees lines for the next request
    rel(3, 1, 2); tick();
    chk("R10 owner release no flag", int'(rel_err), 0);
    req(4, 1, 2); tick(); tick();
    chk("R9 freed lines granted", int'(resp_ack), 1);

    // line already held by requester
    req(4, 1, 5); tick(); tick();
    chk("R8 self-held line no conflict", int'(resp_ack), 1);

    // table full: 7, 1, 2, 5 held
    req(0, 8, 8); tick(); tick();
    chk("R7 refused when table full", int'(resp_ack), 0);
    rel(5, 7, 7); tick();
    req(0, 8, 8); tick(); tick();
    chk("R7 R6 one free entry suffices", int'(resp_ack), 1);
    rel(9, 3, 3);
    s_relt = TW'(2); tick();
    chk("R10 unlocked line release no flag", int'(rel_err), 0);
    drain_all();

    // burst from all threads fills slots and drops requests
    for (int c = 0; c < 3; c++) begin
      for (int t = 0; t < N; t++) req(t, t, t + 8);
      tick();
    end
    chk("R1 slots saturated", int'(req_ready), 32'h04);
    chk("R2 rotation order", int'(resp_tid), 2);
    drain_all();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int t = 0; t < N; t++) begin
        if ($urandom % 4 == 0) begin
          int a;
          a = int'($urandom % 16);
          req(t, a, ($urandom % 8 == 0) ? a : int'($urandom % 16));
        end
      end
      if ($urandom % 3 == 0) begin
        int i;
        i = int'($urandom % D);
        if (mv[i])
          rel(($urandom % 4 == 0) ? int'($urandom % N) : mo[i], int'(ma[i]), int'($urandom % 16));
        else
          rel(int'($urandom % N), int'($urandom % 16), int'($urandom % 16));
      end
      tick();
    end
    drain_all();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule